// File: doc/BRIEF.md
# Eight-Port Shuffle-Exchange Request Router

This block carries up to eight parallel requests from processing elements to eight memory ports in a single combinational pass through three ranks of two-by-two exchange elements. Each rank is preceded by a perfect-shuffle rewiring, and every element steers its traffic from one bit of the request's destination address. No central arbiter is involved, so each element decides for itself.

Two requests can need the same internal link even when their final destinations differ. In that case one request is delivered and the other is dropped, and a per-source flag reports the drop. Results are registered: one clock after the inputs are sampled, each output port shows whether it holds a request, the payload, and the index of the source that sent it. A requester that sees its blocked flag can try again later. Any retry policy belongs outside this block.

Top module: `omega_switch`

## Requirements
- R1: A valid request from source s with destination d that is not blocked appears at output d one clock after it is sampled, with out_valid[d]=1, out_src[d]=s and out_data[d] equal to its payload. Routing works as follows. Before each of the three ranks, line index i moves to ((i<<1)|(i>>2)) mod 8. Element e of a rank joins lines 2e (upper) and 2e+1 (lower). Rank k, counted from 0 at the input side, reads destination bit (2-k): 0 sends the request to the upper output and 1 sends it to the lower output.
- R2: A request that is the only valid one in its cycle is never blocked. It always reaches its destination, for every source and destination pair.
- R3: When both inputs of an element are valid and want the same output, the request on the upper line wins. The request on the lower line is dropped, and blocked is set for its source. For example, source 0 to destination 0 together with source 4 to destination 1 sets blocked[4] and delivers source 0 at output 0.
- R4: Every uniform cyclic shift pattern, where all eight sources are valid and d=(s+c) mod 8, is delivered with no blocked flag set.
- R5: A source with in_valid=0 has no effect, whatever its destination and data. It never raises its own blocked flag, and it produces no output.
- R6: In every cycle, the number of set out_valid bits plus the number of set blocked bits equals the number of valid requests sampled on the previous clock.
- R7: Outputs change only at a rising clock edge. Inputs applied between edges are not visible at the outputs before the next edge.
- R8: A synchronous active-high reset clears every out_valid and blocked bit on the next edge, including while requests are being presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 8 | Request present, one bit per source |
| in_dest | input | 8x3 | Destination port per source |
| in_data | input | 8x16 | Payload per source |
| out_valid | output | 8 | Request delivered, one bit per output port |
| out_data | output | 8x16 | Delivered payload per output port |
| out_src | output | 8x3 | Source index of the delivered request |
| blocked | output | 8 | Request dropped inside the fabric, one bit per source |

## Verification
The hardest case to reach from the ports is a clash in the second or third rank. That happens only when two requests pass through different first-rank elements and then converge, which a naive stimulus seldom produces. The stimulus uses many random full and partial patterns and draws destinations from a narrowed range, so that requests crowd into the same half of the fabric. A behavioural model follows each request through the shuffled positions, settles clashes by which request sits on the even line, and predicts every output and flag. Directed clashes at the first rank, all 64 lone requests and all eight cyclic shifts pin down the cases that are known by hand.

// File: rtl/omega_pkg.sv
package omega_pkg;
    localparam int unsigned PORTS  = 8;
    localparam int unsigned IDX_W  = $clog2(PORTS);
    localparam int unsigned STAGES = IDX_W;
    localparam int unsigned ELEMS  = PORTS / 2;
    localparam int unsigned DATA_W = 16;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  dest;
        logic [IDX_W-1:0]  src;
        logic [DATA_W-1:0] data;
    } flit_t;

    typedef enum logic {
        XC_STRAIGHT = 1'b0,
        XC_CROSS    = 1'b1
    } xset_e;

    localparam flit_t FLIT_IDLE = '0;

    // line position after the perfect shuffle: rotate left by one
    function automatic logic [IDX_W-1:0] shuffle_idx(input logic [IDX_W-1:0] i);
        return {i[IDX_W-2:0], i[IDX_W-1]};
    endfunction
endpackage

// File: rtl/omega_xchg.sv
module omega_xchg
    import omega_pkg::*;
#(
    parameter int unsigned BIT = 0
) (
    input  flit_t            up_in,
    input  flit_t            lo_in,
    output flit_t            up_out,
    output flit_t            lo_out,
    output logic             drop_valid,
    output logic [IDX_W-1:0] drop_src
);
    logic  up_wants_lo;
    logic  lo_wants_lo;
    logic  clash;
    xset_e setting;

    always_comb begin
        up_wants_lo = up_in.dest[BIT];
        lo_wants_lo = lo_in.dest[BIT];
        clash       = up_in.valid && lo_in.valid && (up_wants_lo == lo_wants_lo);

        // the upper request decides the setting whenever it is present
        if (up_in.valid)
            setting = up_wants_lo ? XC_CROSS : XC_STRAIGHT;
        else if (lo_in.valid)
            setting = lo_wants_lo ? XC_STRAIGHT : XC_CROSS;
        else
            setting = XC_STRAIGHT;

        if (setting == XC_STRAIGHT) begin
            up_out = up_in;
            lo_out = lo_in;
        end else begin
            up_out = lo_in;
            lo_out = up_in;
        end

        // the lower request lost: remove the copy that went the wrong way
        if (clash) begin
            if (setting == XC_STRAIGHT)
                lo_out.valid = 1'b0;
            else
                up_out.valid = 1'b0;
        end

        drop_valid = clash;
        drop_src   = lo_in.src;
    end

    always_comb begin
        if (up_in.valid && !lo_in.valid) begin
            AST_XCHG_STEER: assert (up_wants_lo ? (lo_out.valid && lo_out.src == up_in.src && !up_out.valid)
                                                : (up_out.valid && up_out.src == up_in.src && !lo_out.valid)); // R1
        end
        AST_XCHG_CONSERVE: assert ((32'(up_out.valid) + 32'(lo_out.valid) + 32'(drop_valid))
                                   == (32'(up_in.valid) + 32'(lo_in.valid))); // R6
    end
endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int unsigned STAGE = 0
) (
    input  flit_t [PORTS-1:0] lines_in,
    output flit_t [PORTS-1:0] lines_out,
    output logic  [PORTS-1:0] drops
);
    localparam int unsigned ROUTE_BIT = STAGES - 1 - STAGE;

    flit_t [PORTS-1:0]             shuffled;
    logic  [ELEMS-1:0]             drop_v;
    logic  [ELEMS-1:0][IDX_W-1:0]  drop_s;

    always_comb begin
        shuffled = '0;
        for (int j = 0; j < PORTS; j++)
            shuffled[shuffle_idx(j[IDX_W-1:0])] = lines_in[j];
    end

    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
        omega_xchg #(.BIT(ROUTE_BIT)) u_xchg (
            .up_in      (shuffled[2*e]),
            .lo_in      (shuffled[2*e+1]),
            .up_out     (lines_out[2*e]),
            .lo_out     (lines_out[2*e+1]),
            .drop_valid (drop_v[e]),
            .drop_src   (drop_s[e])
        );
    end

    always_comb begin
        drops = '0;
        for (int e = 0; e < ELEMS; e++)
            if (drop_v[e])
                drops[drop_s[e]] = 1'b1;
    end
endmodule

// File: rtl/omega_egress.sv
module omega_egress
    import omega_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  flit_t [PORTS-1:0]             fin,
    input  logic  [PORTS-1:0]             blk_in,
    output logic  [PORTS-1:0]             out_valid,
    output logic  [PORTS-1:0][DATA_W-1:0] out_data,
    output logic  [PORTS-1:0][IDX_W-1:0]  out_src,
    output logic  [PORTS-1:0]             blocked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= '0;
            blocked   <= '0;
            out_data  <= '0;
            out_src   <= '0;
        end else begin
            blocked <= blk_in;
            for (int o = 0; o < PORTS; o++) begin
                out_valid[o] <= fin[o].valid;
                out_data[o]  <= fin[o].data;
                out_src[o]   <= fin[o].src;
            end
        end
    end

    for (genvar o = 0; o < PORTS; o++) begin : g_lane
        AST_LANE_MATCH: assert property (@(posedge clk) disable iff (rst)
            fin[o].valid |-> (fin[o].dest == IDX_W'(o))); // R1
    end
endmodule

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [PORTS-1:0]              in_valid,
    input  logic [PORTS-1:0][IDX_W-1:0]   in_dest,
    input  logic [PORTS-1:0][DATA_W-1:0]  in_data,
    output logic [PORTS-1:0]              out_valid,
    output logic [PORTS-1:0][DATA_W-1:0]  out_data,
    output logic [PORTS-1:0][IDX_W-1:0]   out_src,
    output logic [PORTS-1:0]              blocked
);
    flit_t [STAGES:0][PORTS-1:0] lines;
    logic  [STAGES-1:0][PORTS-1:0] drops;
    logic  [PORTS-1:0] blk_next;

    always_comb begin
        for (int s = 0; s < PORTS; s++) begin
            lines[0][s].valid = in_valid[s];
            lines[0][s].dest  = in_dest[s];
            lines[0][s].src   = s[IDX_W-1:0];
            lines[0][s].data  = in_data[s];
        end
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        omega_stage #(.STAGE(k)) u_stage (
            .lines_in  (lines[k]),
            .lines_out (lines[k+1]),
            .drops     (drops[k])
        );
    end

    always_comb begin
        blk_next = '0;
        for (int k = 0; k < STAGES; k++)
            blk_next |= drops[k];
    end

    omega_egress u_egress (
        .clk       (clk),
        .rst       (rst),
        .fin       (lines[STAGES]),
        .blk_in    (blk_next),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_src   (out_src),
        .blocked   (blocked)
    );

    // checker state: the requests sampled on the previous clock
    logic [PORTS-1:0]             chk_vld_q;
    logic [PORTS-1:0][IDX_W-1:0]  chk_dest_q;
    logic [PORTS-1:0][DATA_W-1:0] chk_data_q;

    always_ff @(posedge clk) begin
        if (rst) chk_vld_q <= '0;
        else     chk_vld_q <= in_valid;
        chk_dest_q <= in_dest;
        chk_data_q <= in_data;
    end

    for (genvar s = 0; s < PORTS; s++) begin : g_chk
        AST_DELIVER: assert property (@(posedge clk) disable iff (rst)
            (chk_vld_q[s] && !blocked[s]) |->
                (out_valid[chk_dest_q[s]] && out_src[chk_dest_q[s]] == IDX_W'(s)
                 && out_data[chk_dest_q[s]] == chk_data_q[s])); // R1
        AST_BLOCK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
            blocked[s] |-> chk_vld_q[s]); // R5
    end

    AST_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        ($countones(out_valid) + $countones(blocked)) == $countones(chk_vld_q)); // R6
    AST_LONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($countones(chk_vld_q) == 1) |-> (blocked == '0)); // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (out_valid == '0 && blocked == '0)); // R8
endmodule

// File: tb/omega_switch_tb.sv
module omega_switch_tb;
    import omega_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PORTS-1:0]             in_valid = '0;
    logic [PORTS-1:0][IDX_W-1:0]  in_dest  = '0;
    logic [PORTS-1:0][DATA_W-1:0] in_data  = '0;
    logic [PORTS-1:0]             out_valid;
    logic [PORTS-1:0][DATA_W-1:0] out_data;
    logic [PORTS-1:0][IDX_W-1:0]  out_src;
    logic [PORTS-1:0]             blocked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int exp_valid [PORTS];
    int exp_src   [PORTS];
    int exp_data  [PORTS];
    int exp_blk   [PORTS];

    always #5 clk = ~clk;

    omega_switch u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_src(out_src), .blocked(blocked)
    );

    task automatic check(input string req, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // behavioural model: follow each request by its line position
    task automatic model();
        int pos [PORTS];
        int want[PORTS];
        bit alive[PORTS];
        bit kill[PORTS];
        for (int s = 0; s < PORTS; s++) begin
            alive[s] = in_valid[s];
            pos[s] = s;
            exp_blk[s] = 0;
            exp_valid[s] = 0; exp_src[s] = 0; exp_data[s] = 0;
        end
        for (int k = 0; k < STAGES; k++) begin
            for (int s = 0; s < PORTS; s++) begin
                pos[s]  = ((pos[s] << 1) | (pos[s] >> 2)) & 7;
                want[s] = (pos[s] & 6) | ((int'(in_dest[s]) >> (2 - k)) & 1);
                kill[s] = 0;
            end
            for (int s = 0; s < PORTS; s++)
                for (int t = 0; t < PORTS; t++)
                    if (alive[s] && alive[t] && s != t && want[s] == want[t] && (pos[t] % 2 == 0))
                        kill[s] = 1;
            for (int s = 0; s < PORTS; s++) begin
                if (kill[s]) begin alive[s] = 0; exp_blk[s] = 1; end
                pos[s] = want[s];
            end
        end
        for (int s = 0; s < PORTS; s++)
            if (alive[s]) begin
                exp_valid[pos[s]] = 1;
                exp_src[pos[s]]   = s;
                exp_data[pos[s]]  = int'(in_data[s]);
            end
    endtask

    task automatic compare(input string req);
        for (int o = 0; o < PORTS; o++) begin
            check(req, $sformatf("out_valid[%0d]", o), int'(out_valid[o]), exp_valid[o]);
            if (exp_valid[o] != 0) begin
                check(req, $sformatf("out_src[%0d]", o), int'(out_src[o]), exp_src[o]);
                check(req, $sformatf("out_data[%0d]", o), int'(out_data[o]), exp_data[o]);
            end
            check(req, $sformatf("blocked[%0d]", o), int'(blocked[o]), exp_blk[o]);
        end
    endtask

    // inputs are already driven (at a negedge); predict, clock, compare at the next negedge
    task automatic step(input string req);
        model();
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic idle_all();
        in_valid = '0;
        for (int s = 0; s < PORTS; s++) begin
            in_dest[s] = IDX_W'($urandom);
            in_data[s] = DATA_W'($urandom);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // reset, with a request presented to show reset dominates
        in_valid = '1;
        repeat (3) @(negedge clk);
        check("R8", "out_valid after reset", int'(out_valid), 0);
        check("R8", "blocked after reset", int'(blocked), 0);
        rst = 1'b0;
        idle_all();
        step("R5");

        // R7: between edges new inputs do not reach the outputs
        in_valid = 8'b0000_0001; in_dest[0] = 3'd5; in_data[0] = 16'hBEEF;
        #1;
        check("R7", "out_valid before edge", int'(out_valid), 0);
        step("R7");

        // R2 / R1: every lone source and destination pair
        for (int s = 0; s < PORTS; s++)
            for (int d = 0; d < PORTS; d++) begin
                idle_all();
                in_valid[s] = 1'b1;
                in_dest[s]  = IDX_W'(d);
                in_data[s]  = DATA_W'(s * 256 + d + 16'h1000);
                step("R2");
                check("R1", "lone delivery at dest", int'(out_valid[d]), 1);
            end

        // R3: directed clash at the first rank
        idle_all();
        in_valid = 8'b0001_0001;
        in_dest[0] = 3'd0; in_data[0] = 16'hAAAA;
        in_dest[4] = 3'd1; in_data[4] = 16'h5555;
        step("R3");
        check("R3", "lower line loser flagged", int'(blocked[4]), 1);
        check("R3", "upper line winner src", int'(out_src[0]), 0);
        check("R3", "loser has no output", int'(out_valid[1]), 0);

        // R3: same pair swapped destinations, still clash on bit 2
        idle_all();
        in_valid = 8'b0001_0001;
        in_dest[0] = 3'd3; in_dest[4] = 3'd2;
        step("R3");
        check("R3", "swapped clash loser", int'(blocked[4]), 1);

        // R4 / R1: uniform cyclic shifts
        for (int c = 0; c < PORTS; c++) begin
            in_valid = '1;
            for (int s = 0; s < PORTS; s++) begin
                in_dest[s] = IDX_W'((s + c) % PORTS);
                in_data[s] = DATA_W'($urandom);
            end
            step("R4");
            check("R4", "no blocking on shift", int'(blocked), 0);
            check("R4", "all outputs valid on shift", int'(out_valid), 255);
        end

        // R5: invalid inputs with garbage fields have no effect
        for (int i = 0; i < 20; i++) begin
            idle_all();
            step("R5");
            check("R5", "no output from idle", int'(out_valid), 0);
        end

        // R6 / R1 / R3: random traffic, destinations sometimes crowded
        for (int i = 0; i < 3000; i++) begin
            in_valid = PORTS'($urandom);
            for (int s = 0; s < PORTS; s++) begin
                in_dest[s] = (i % 3 == 0) ? IDX_W'($urandom % 2) : IDX_W'($urandom);
                in_data[s] = DATA_W'($urandom);
            end
            step("R6");
            check("R6", "conservation", $countones(out_valid) + $countones(blocked),
                  $countones(in_valid));
        end

        // R8: reset in the middle of traffic
        in_valid = '1;
        for (int s = 0; s < PORTS; s++) in_dest[s] = 3'd0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8", "out_valid after mid reset", int'(out_valid), 0);
        check("R8", "blocked after mid reset", int'(blocked), 0);
        rst = 1'b0;
        idle_all();
        step("R8");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule